// File: doc/BRIEF.md
# Frequency Sweep and Burst Controller

This block drives the frequency word of a direct digital synthesis core through a programmed sweep. Software loads a start frequency, a step increment, a number of steps, an active interval, a listen interval and a few mode bits through a simple register-write port. A start strobe then launches the sweep. Each frequency is held for its active interval and the word is then advanced by the increment. Steps are timed either by an internal down-counter or by rising edges of an external step pin. In burst mode every active interval is followed by a listen interval, during which the output is forced to midscale.

The controller tells the synthesis core when to clear its phase. This happens always at start, and at each step only when the phase-restart bit is set; otherwise the phase runs on continuously. A one-cycle step strobe marks every new frequency word. A one-cycle done pulse marks the end of the sweep, and after it the final frequency stays on the output. A standby input freezes all sequencing.

The state machine has four states:
- IDLE: after reset; output at midscale.
- ACTIVE: a frequency is being output.
- LISTEN: the burst gap; output at midscale.
- DONE: the final frequency is held.

Its transitions are:
- start: from any state to ACTIVE, loading the start frequency.
- step: ACTIVE to ACTIVE (continuous mode) or LISTEN to ACTIVE (burst mode), adding the increment.
- gap: ACTIVE to LISTEN, in burst mode when the active interval ends.
- finish: ACTIVE or LISTEN to DONE, when the step count is used up.

Top module: `fsweep_ctrl`

## Requirements
- R1: After reset, freq_word is 0, midscale is 1, and step_strobe, phase_restart and sweep_done are 0.
- R2: A write with wr_en high stores wr_data into a setting. The addresses are: 0 start frequency, 1 increment, 2 step count (low 12 bits), 3 active interval (low 12 bits), 4 listen interval (low 12 bits), 5 mode. The mode bits are: bit0 burst, bit1 external stepping, bit2 phase restart on each step. With wr_en low, nothing is stored.
- R3: One cycle after a start strobe, freq_word equals the start frequency, step_strobe and phase_restart are 1, and midscale is 0.
- R4: In continuous mode with internal timing, each frequency is held for the active-interval count of clock cycles. The word then becomes the previous value plus the increment, modulo 2^24.
- R5: An interval value of 0 behaves as 1 cycle.
- R6: In burst mode, each frequency is output for the active interval. midscale is then 1 for the listen interval, and then the next frequency appears.
- R7: With external stepping, the internal timer is ignored. Each rising edge of ext_step, after a two-flop synchroniser, causes exactly one step.
- R8: phase_restart pulses together with step_strobe on every step when mode bit2 is 1, and only at start when it is 0.
- R9: After step-count steps, the interval of the last frequency ends and sweep_done pulses for one cycle. freq_word then stays at start + count × increment, with midscale 0.
- R10: While standby is 1, freq_word, the sequencing state and the timers do not change, and no step occurs.
- R11: step_strobe is 1 exactly in the cycles where a newly loaded frequency word first appears. freq_word never changes without it.
- R12: A start strobe in the middle of a sweep restarts it from the start frequency with a cleared step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Setting write enable |
| wr_addr | input | 3 | Setting address |
| wr_data | input | 24 | Setting write data |
| start | input | 1 | Sweep start strobe |
| standby | input | 1 | Freeze all sequencing |
| ext_step | input | 1 | Asynchronous external step pin |
| freq_word | output | 24 | Frequency word to the synthesis core |
| midscale | output | 1 | Force the output to midscale |
| phase_restart | output | 1 | Clear the phase accumulator |
| step_strobe | output | 1 | A new frequency word appears this cycle |
| sweep_done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
Seeded random sweeps vary the start word, increment, step count, both intervals (including zero), burst mode and the phase bit. For each sweep, the expected word, strobe, phase-restart, midscale and done timeline is computed cycle by cycle. This separates errors in interval length, in where the listen gap is placed, in increment arithmetic including wrap, and in the final-step count. Directed cases cover external stepping: a long quiet stretch shows that the timer is ignored, and held pin levels show one step per edge. Further directed cases cover standby in the middle of an interval, a restart in the middle of a sweep, a write with the enable low, and a sweep with a step count of zero.

// File: rtl/fsweep_pkg.sv
package fsweep_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACTIVE = 2'd1,
        S_LISTEN = 2'd2,
        S_DONE   = 2'd3
    } fsweep_state_e;

    localparam logic [2:0] ADDR_START  = 3'd0;
    localparam logic [2:0] ADDR_INCR   = 3'd1;
    localparam logic [2:0] ADDR_COUNT  = 3'd2;
    localparam logic [2:0] ADDR_ACTIVE = 3'd3;
    localparam logic [2:0] ADDR_LISTEN = 3'd4;
    localparam logic [2:0] ADDR_MODE   = 3'd5;

    localparam int MODE_BURST = 0;
    localparam int MODE_EXT   = 1;
    localparam int MODE_PHASE = 2;
endpackage

// File: rtl/fsweep_edge_sync.sv
module fsweep_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R7: a single edge never yields two consecutive step requests
    a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/fsweep_interval_timer.sv
module fsweep_interval_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= load_val;
        else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R5: the counter rests at zero and never wraps
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/fsweep_ctrl.sv
module fsweep_ctrl
    import fsweep_pkg::*;
#(
    parameter int FREQ_W = 24,
    parameter int CNT_W  = 12,
    parameter int TMR_W  = 12,
    parameter int ADDR_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FREQ_W-1:0] wr_data,
    input  logic              start,
    input  logic              standby,
    input  logic              ext_step,
    output logic [FREQ_W-1:0] freq_word,
    output logic              midscale,
    output logic              phase_restart,
    output logic              step_strobe,
    output logic              sweep_done
);
    localparam int MODE_W = 3;

    logic [FREQ_W-1:0] start_q, incr_q;
    logic [CNT_W-1:0]  count_q, step_q;
    logic [TMR_W-1:0]  active_q, listen_q;
    logic [MODE_W-1:0] mode_q;

    fsweep_state_e state_q, state_d;
    logic [FREQ_W-1:0] freq_q;
    logic strobe_q, phase_q, done_q;

    logic ext_rise, tmr_expired, tmr_load, tmr_run;
    logic [TMR_W-1:0] tmr_val;
    logic ld_start, adv, fin, trig;

    function automatic logic [TMR_W-1:0] span_to_load(input logic [TMR_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= '0;
            incr_q   <= '0;
            count_q  <= '0;
            active_q <= '0;
            listen_q <= '0;
            mode_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_START:  start_q  <= wr_data;
                ADDR_INCR:   incr_q   <= wr_data;
                ADDR_COUNT:  count_q  <= wr_data[CNT_W-1:0];
                ADDR_ACTIVE: active_q <= wr_data[TMR_W-1:0];
                ADDR_LISTEN: listen_q <= wr_data[TMR_W-1:0];
                ADDR_MODE:   mode_q   <= wr_data[MODE_W-1:0];
                default: ;
            endcase
        end
    end

    fsweep_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(ext_step), .rise(ext_rise)
    );

    fsweep_interval_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .expired(tmr_expired)
    );

    assign tmr_run = !standby && (state_q == S_ACTIVE || state_q == S_LISTEN);
    assign trig    = mode_q[MODE_EXT] ? ext_rise : tmr_expired;

    // next state and sequencing decisions
    always_comb begin
        state_d  = state_q;
        ld_start = 1'b0;
        adv      = 1'b0;
        fin      = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = span_to_load(active_q);
        if (!standby) begin
            if (start) begin
                state_d  = S_ACTIVE;
                ld_start = 1'b1;
                tmr_load = 1'b1;
            end else begin
                unique case (state_q)
                    S_IDLE, S_DONE: ;
                    S_ACTIVE: begin
                        if (trig && mode_q[MODE_BURST]) begin
                            state_d  = S_LISTEN;
                            tmr_load = 1'b1;
                            tmr_val  = span_to_load(listen_q);
                        end else if (trig) begin
                            adv = 1'b1;
                        end
                    end
                    S_LISTEN: adv = tmr_expired;
                endcase
                if (adv && step_q == count_q) begin
                    adv     = 1'b0;
                    fin     = 1'b1;
                    state_d = S_DONE;
                end else if (adv) begin
                    state_d  = S_ACTIVE;
                    tmr_load = 1'b1;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q   <= '0;
            step_q   <= '0;
            strobe_q <= 1'b0;
            phase_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            phase_q  <= 1'b0;
            done_q   <= fin;
            if (ld_start) begin
                freq_q   <= start_q;
                step_q   <= '0;
                strobe_q <= 1'b1;
                phase_q  <= 1'b1;
            end else if (adv) begin
                freq_q   <= freq_q + incr_q;
                step_q   <= step_q + 1'b1;
                strobe_q <= 1'b1;
                phase_q  <= mode_q[MODE_PHASE];
            end
        end
    end

    assign freq_word     = freq_q;
    assign midscale      = (state_q == S_IDLE) || (state_q == S_LISTEN);
    assign phase_restart = phase_q;
    assign step_strobe   = strobe_q;
    assign sweep_done    = done_q;

    a_r11_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_word) |-> step_strobe);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);
    a_r9_done_state: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> (state_q == S_DONE && !midscale));
    a_r10_standby_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ($stable(freq_word) && !step_strobe && $stable(state_q)));
    a_r8_phase_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        phase_restart |-> step_strobe);
endmodule

// File: tb/fsweep_ctrl_bench.sv
`timescale 1ns/1ps
module fsweep_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        start = 1'b0, standby = 1'b0, ext_step = 1'b0;
    logic [23:0] freq_word;
    logic        midscale, phase_restart, step_strobe, sweep_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2.5 clk = ~clk;

    fsweep_ctrl u_fsweep_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .standby(standby),
        .ext_step(ext_step), .freq_word(freq_word), .midscale(midscale),
        .phase_restart(phase_restart), .step_strobe(step_strobe),
        .sweep_done(sweep_done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    function automatic int span(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // full timeline check of an internally timed sweep (R4, R5, R6, R8, R9, R11)
    task automatic run_sweep(input logic [23:0] sf, input logic [23:0] inc, input int n,
                             input int d, input int l, input bit burst, input bit ph);
        int p, dm, endc;
        dm = span(d);
        p  = burst ? dm + span(l) : dm;
        endc = (n + 1) * p;
        wr(3'd0, sf); wr(3'd1, inc); wr(3'd2, 24'(n));
        wr(3'd3, 24'(d)); wr(3'd4, 24'(l)); wr(3'd5, {21'd0, ph, 1'b0, burst});
        kick();
        for (int c = 0; c < endc + 4; c++) begin
            int k;
            logic [23:0] expf;
            bit es, ep, em, ed;
            k    = (c / p > n) ? n : c / p;
            expf = sf + 24'(k) * inc;
            es   = (c % p == 0) && (c / p <= n);
            ep   = es && (c == 0 || ph);
            em   = burst && (c < endc) && ((c % p) >= dm);
            ed   = (c == endc);
            chk(freq_word === expf, "R4 freq word", freq_word, expf);
            chk(step_strobe === es, "R11 step strobe", step_strobe, es);
            chk(phase_restart === ep, "R8 phase restart", phase_restart, ep);
            chk(midscale === em, "R6 midscale", midscale, em);
            chk(sweep_done === ed, "R9 done pulse", sweep_done, ed);
            @(negedge clk);
        end
    endtask

    initial begin
        int unsigned seed_init;
        int strobes, dones;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(freq_word === 24'd0, "R1 freq", freq_word, 0);
        chk(midscale === 1'b1, "R1 midscale", midscale, 1);
        chk(step_strobe === 1'b0 && phase_restart === 1'b0 && sweep_done === 1'b0,
            "R1 pulses", {step_strobe, phase_restart, sweep_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: zero intervals in burst (R5), single frequency, wrap
        run_sweep(24'h000100, 24'h000010, 3, 0, 0, 1'b1, 1'b1);
        run_sweep(24'h00ABCD, 24'h000001, 0, 2, 0, 1'b0, 1'b0);
        run_sweep(24'hFFFFF0, 24'h000020, 2, 1, 3, 1'b0, 1'b1);

        // random sweeps
        for (int i = 0; i < 10; i++) begin
            run_sweep(24'($urandom), 24'($urandom), int'($urandom % 5),
                      int'($urandom % 6), int'($urandom % 6),
                      1'($urandom), 1'($urandom));
        end

        // R3 and R2: start loads the programmed word; disabled write ignored
        wr(3'd0, 24'h123456);
        wr(3'd3, 24'd50); wr(3'd2, 24'd2); wr(3'd5, 24'd0);
        wr_addr = 3'd0; wr_data = 24'h777777;
        @(negedge clk);
        kick();
        chk(freq_word === 24'h123456, "R2 no write when disabled", freq_word, 24'h123456);
        chk(step_strobe === 1'b1 && phase_restart === 1'b1, "R3 start pulses",
            {step_strobe, phase_restart}, 2'b11);
        chk(midscale === 1'b0, "R3 midscale low", midscale, 0);

        // R12 restart mid-sweep
        wr(3'd0, 24'd1000); wr(3'd1, 24'd7); wr(3'd2, 24'd5); wr(3'd3, 24'd3);
        kick();
        repeat (4) @(negedge clk);
        chk(freq_word === 24'd1007, "R12 pre-restart step", freq_word, 1007);
        kick();
        chk(freq_word === 24'd1000 && step_strobe === 1'b1, "R12 restart load", freq_word, 1000);
        repeat (3) @(negedge clk);
        chk(freq_word === 24'd1007, "R12 restart timing", freq_word, 1007);

        // R10 standby freeze
        wr(3'd0, 24'd5); wr(3'd1, 24'd1); wr(3'd2, 24'd3); wr(3'd3, 24'd4);
        kick();
        repeat (2) @(negedge clk);
        standby = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk(freq_word === 24'd5 && step_strobe === 1'b0, "R10 frozen", freq_word, 5);
        end
        standby = 1'b0;
        strobes = 0; dones = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            strobes += int'(step_strobe);
            dones   += int'(sweep_done);
        end
        chk(strobes == 3, "R10 resume steps", strobes, 3);
        chk(dones == 1 && freq_word === 24'd8, "R10 resume end", freq_word, 8);

        // R7 external stepping
        wr(3'd0, 24'd100); wr(3'd1, 24'd10); wr(3'd2, 24'd2); wr(3'd3, 24'd2);
        wr(3'd5, 24'd2);
        kick();
        strobes = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            strobes += int'(step_strobe);
        end
        chk(strobes == 0 && freq_word === 24'd100, "R7 timer ignored", strobes, 0);
        for (int e = 1; e <= 3; e++) begin
            strobes = 0; dones = 0;
            ext_step = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                strobes += int'(step_strobe);
                dones   += int'(sweep_done);
            end
            ext_step = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                strobes += int'(step_strobe);
                dones   += int'(sweep_done);
            end
            chk(strobes == ((e <= 2) ? 1 : 0), "R7 one step per edge", strobes, (e <= 2) ? 1 : 0);
            chk(dones == ((e == 3) ? 1 : 0), "R9 external done", dones, (e == 3) ? 1 : 0);
            chk(freq_word === 24'(100 + 10 * ((e <= 2) ? e : 2)), "R7 word", freq_word,
                100 + 10 * ((e <= 2) ? e : 2));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule